// File: doc/BRIEF.md
# Address-Line Edge Scanline Counter

This block counts video scanlines without a horizontal sync. It watches one bit of the video memory address bus, the A12 line. That bit goes high when the video generator starts fetching sprite patterns, at around pixel cycle 260 of a 341-cycle line. Background fetches near cycle 256 do not raise it. Only the first rising edge after a long low stretch is taken as a line tick. The brief high-low-high toggles that follow inside the same line are rejected.

Each accepted tick advances a down counter. When the counter is zero, or when the CPU has asked for a restart, a tick loads the programmed period instead. When a tick leaves the counter at zero and interrupts are enabled, an active-high interrupt request is raised and held until the CPU services it.

The CPU side uses single-cycle write strobes:
- load the period,
- request a restart,
- enable,
- disable (which also drops a pending request),
- acknowledge.

All signals are synchronous to the pixel clock.

Top module: `a12_scanline_irq`

## Requirements
- R1: A rising edge of `a12_i` is accepted as a tick only if `a12_i` was sampled low on at least LOW_MIN (default 8) consecutive clocks just before it. A high pulse after a shorter low stretch is ignored.
- R2: A tick is counted once, however long `a12_i` then stays high.
- R3: On a tick, the counter loads the period when it is zero or a restart is pending. Otherwise the tick decrements the counter. With period N and no restarts, requests come every N+1 ticks.
- R4: If a tick leaves the counter at zero while interrupts are enabled, `irq_o` is set. A period of 0 therefore raises a request on every tick.
- R5: Once set, `irq_o` stays high until an `ack_i` strobe clears it.
- R6: A `wr_disable_i` strobe clears `irq_o` and blocks new requests until a `wr_enable_i` strobe.
- R7: A `wr_clear_i` strobe makes the next tick reload the period, whatever the counter holds.
- R8: When a zero-reaching tick and `ack_i` fall in the same cycle, `irq_o` ends that cycle set.
- R9: When a zero-reaching tick and `wr_disable_i` fall in the same cycle, `irq_o` ends that cycle clear.
- R10: After reset, `irq_o` is low, interrupts are disabled, and both the counter and the period are zero.
- R11: `irq_o` rises on the second clock edge after the one that samples `a12_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a12_i | input | 1 | Watched video address bit |
| wr_reload_i | input | 1 | Strobe: latch `reload_val_i` as the period |
| reload_val_i | input | CNT_W | Period value |
| wr_clear_i | input | 1 | Strobe: reload on the next tick |
| wr_enable_i | input | 1 | Strobe: enable requests |
| wr_disable_i | input | 1 | Strobe: disable requests and clear `irq_o` |
| ack_i | input | 1 | Strobe: clear `irq_o` |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Two pairs of events can land in the same clock edge:
- the counter's zero-reaching update and an acknowledge;
- the counter's zero-reaching update and a disable write.

The bench provokes each pair by holding the strobe across exactly the edge that follows the tick pulse. That edge is the one after `a12_i` is first sampled high.

The outcome is judged from `irq_o` one half-cycle later:
- with an acknowledge, the request must survive;
- with a disable, no request may appear.

An acknowledge on a quiet cycle is checked too, to show that it does clear.

// File: rtl/a12_cnt_pkg.sv
package a12_cnt_pkg;
  parameter int unsigned CNT_W_DEF   = 8;
  parameter int unsigned LOW_MIN_DEF = 8;

  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_LOAD,
    ACT_DEC
  } cnt_act_e;
endpackage

// File: rtl/a12_edge_filter.sv
module a12_edge_filter #(
  parameter int unsigned LOW_MIN = a12_cnt_pkg::LOW_MIN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a12_i,
  output logic edge_o
);
  localparam int unsigned LW = $clog2(LOW_MIN + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(LOW_MIN);

  logic [LW-1:0] low_q;
  logic          edge_q;

  // low_q saturates at LOW_SAT; any high sample resets it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= a12_i && (low_q == LOW_SAT);
      if (a12_i)                low_q <= '0;
      else if (low_q != LOW_SAT) low_q <= low_q + 1'b1;
    end
  end

  assign edge_o = edge_q;
endmodule

// File: rtl/scanline_down_counter.sv
module scanline_down_counter
  import a12_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             wr_clear_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] period_q, cnt_q, cnt_nxt;
  logic             pend_q;
  cnt_act_e         act;

  always_comb begin
    if (!tick_i)                     act = ACT_HOLD;
    else if (cnt_q == '0 || pend_q)  act = ACT_LOAD;
    else                             act = ACT_DEC;
  end

  always_comb begin
    unique case (act)
      ACT_LOAD: cnt_nxt = period_q;
      ACT_DEC:  cnt_nxt = cnt_q - 1'b1;
      default:  cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_reload_i) period_q <= reload_val_i;
      cnt_q <= cnt_nxt;
      // a fresh restart request survives a tick in the same cycle
      if (wr_clear_i)  pend_q <= 1'b1;
      else if (tick_i) pend_q <= 1'b0;
    end
  end

  assign hit_o = (act != ACT_HOLD) && (cnt_nxt == '0);
endmodule

// File: rtl/scanline_irq_flag.sv
module scanline_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic wr_enable_i,
  input  logic wr_disable_i,
  input  logic ack_i,
  output logic irq_o
);
  logic en_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (wr_disable_i)     en_q <= 1'b0;
      else if (wr_enable_i) en_q <= 1'b1;
      // new event beats ack; disable beats new event
      if (hit_i && en_q && !wr_disable_i) irq_q <= 1'b1;
      else if (ack_i || wr_disable_i)     irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/a12_scanline_irq.sv
module a12_scanline_irq
  import a12_cnt_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned LOW_MIN = LOW_MIN_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a12_i,
  input  logic             wr_reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             wr_clear_i,
  input  logic             wr_enable_i,
  input  logic             wr_disable_i,
  input  logic             ack_i,
  output logic             irq_o
);
  logic tick_w, hit_w;

  a12_edge_filter #(.LOW_MIN(LOW_MIN)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a12_i  (a12_i),
    .edge_o (tick_w)
  );

  scanline_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_w),
    .wr_reload_i  (wr_reload_i),
    .reload_val_i (reload_val_i),
    .wr_clear_i   (wr_clear_i),
    .hit_o        (hit_w)
  );

  scanline_irq_flag u_flag (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit_w),
    .wr_enable_i  (wr_enable_i),
    .wr_disable_i (wr_disable_i),
    .ack_i        (ack_i),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/a12_scanline_irq_chk.sv
module a12_scanline_irq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic a12_i,
  input logic tick_i,
  input logic hit_i,
  input logic ack_i,
  input logic wr_disable_i,
  input logic irq_o
);
  assert_tick_after_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> ($past(a12_i) && !$past(a12_i, 2)));

  assert_single_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  assert_rise_needs_hit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(hit_i));

  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hit_i) |=> !irq_o);

  assert_irq_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i && !wr_disable_i) |=> irq_o);

  assert_disable_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_disable_i |=> !irq_o);
endmodule

bind a12_scanline_irq a12_scanline_irq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .a12_i        (a12_i),
  .tick_i       (tick_w),
  .hit_i        (hit_w),
  .ack_i        (ack_i),
  .wr_disable_i (wr_disable_i),
  .irq_o        (irq_o)
);

// File: tb/a12_scanline_irq_tb.sv
module a12_scanline_irq_tb;
  localparam int CNT_W = 8;
  localparam int LOW_MIN = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic a12_i = 1'b1;
  logic wr_reload_i = 1'b0;
  logic [CNT_W-1:0] reload_val_i = '0;
  logic wr_clear_i = 1'b0;
  logic wr_enable_i = 1'b0;
  logic wr_disable_i = 1'b0;
  logic ack_i = 1'b0;
  logic irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  a12_scanline_irq #(.CNT_W(CNT_W), .LOW_MIN(LOW_MIN)) u_dut (
    .clk_i, .rst_ni, .a12_i, .wr_reload_i, .reload_val_i, .wr_clear_i,
    .wr_enable_i, .wr_disable_i, .ack_i, .irq_o
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%0b expected %0b", req, act, exp);
    end
  endtask

  // one line: low stretch, then high; strobes optionally on the counter update edge
  task automatic line(input int low_len, input int hi_len, input bit ack_upd,
                      input bit dis_upd, output logic mid, output logic fin);
    a12_i = 1'b0;
    repeat (low_len) @(negedge clk_i);
    a12_i = 1'b1;
    @(negedge clk_i);
    mid = irq_o;
    ack_i = ack_upd;
    wr_disable_i = dis_upd;
    @(negedge clk_i);
    ack_i = 1'b0;
    wr_disable_i = 1'b0;
    fin = irq_o;
    repeat (hi_len) @(negedge clk_i);
  endtask

  task automatic run_line(input int low_len, output logic fin);
    logic m;
    line(low_len, 2, 1'b0, 1'b0, m, fin);
  endtask

  task automatic do_reload(input logic [CNT_W-1:0] v);
    reload_val_i = v; wr_reload_i = 1'b1; @(negedge clk_i); wr_reload_i = 1'b0;
  endtask
  task automatic do_clear();   wr_clear_i = 1'b1;   @(negedge clk_i); wr_clear_i = 1'b0;   endtask
  task automatic do_enable();  wr_enable_i = 1'b1;  @(negedge clk_i); wr_enable_i = 1'b0;  endtask
  task automatic do_disable(); wr_disable_i = 1'b1; @(negedge clk_i); wr_disable_i = 1'b0; endtask
  task automatic do_ack();     ack_i = 1'b1;        @(negedge clk_i); ack_i = 1'b0;        endtask

  task automatic t_reset();
    logic f;
    chk("R10 irq low after reset", irq_o, 1'b0);
    // period 0 loads on a tick, but interrupts are disabled
    run_line(12, f);
    chk("R10 disabled after reset", f, 1'b0);
  endtask

  task automatic t_basic();
    logic m, f;
    do_reload(8'd3); do_enable(); do_clear();
    for (int i = 0; i < 3; i++) begin
      run_line(12, f);
      chk("R3 no request before count ends", f, 1'b0);
    end
    line(12, 2, 1'b0, 1'b0, m, f);
    chk("R11 irq still low one edge after high sample", m, 1'b0);
    chk("R4 request at zero", f, 1'b1);
    run_line(12, f);
    chk("R5 held without ack", f, 1'b1);
    do_ack();
    chk("R5 ack clears", irq_o, 1'b0);
    run_line(12, f); chk("R3 period line 1", f, 1'b0);
    run_line(12, f); chk("R3 period line 2", f, 1'b0);
    run_line(12, f); chk("R3 request every N+1 ticks", f, 1'b1);
    do_ack();
  endtask

  task automatic t_filter();
    logic m, f;
    run_line(LOW_MIN, f);
    chk("R1 low of exactly LOW_MIN counts (load)", f, 1'b0);
    for (int i = 0; i < 3; i++) begin
      run_line(LOW_MIN - 1, f);
      chk("R1 short low ignored", f, 1'b0);
    end
    // long high hold: counted once only
    line(LOW_MIN, 30, 1'b0, 1'b0, m, f);
    chk("R2 long high counted once", f, 1'b0);
    run_line(LOW_MIN, f);
    chk("R2 one tick per edge", f, 1'b0);
    run_line(LOW_MIN, f);
    chk("R1 third accepted tick reaches zero", f, 1'b1);
    do_ack();
  endtask

  task automatic t_clear();
    logic f;
    run_line(12, f); // counter 0 -> load 3
    run_line(12, f); // 2
    do_clear();
    run_line(12, f); chk("R7 restart reloads", f, 1'b0);
    run_line(12, f); chk("R7 no early zero after restart", f, 1'b0);
    run_line(12, f); chk("R7 count 1", f, 1'b0);
    run_line(12, f); chk("R7 zero after full period", f, 1'b1);
    do_ack();
  endtask

  task automatic t_zero_and_same_cycle();
    logic m, f;
    do_reload(8'd0); do_clear();
    run_line(12, f);
    chk("R4 period 0 fires on tick", f, 1'b1);
    line(12, 2, 1'b1, 1'b0, m, f);
    chk("R8 hit with ack keeps irq", f, 1'b1);
    do_ack();
    chk("R5 quiet ack clears", irq_o, 1'b0);
    line(12, 2, 1'b0, 1'b1, m, f);
    chk("R9 hit with disable leaves irq clear", f, 1'b0);
    run_line(12, f);
    chk("R6 blocked while disabled", f, 1'b0);
    do_enable();
    run_line(12, f);
    chk("R6 re-enabled fires", f, 1'b1);
    do_disable();
    chk("R6 disable clears irq", irq_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_filter();
    t_clear();
    t_zero_and_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: state=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule